// File: doc/BRIEF.md
# Oversampled FSK Bit Synchroniser

This block turns a sliced, demodulated FSK data stream into recovered bits and a bit strobe. The serial input is sampled on every cycle of a clock that runs at a fixed multiple of the nominal bit rate. The default is 29 samples per bit, which at 115.2 kbps is a clock of about 3.34 MHz. A majority vote over the most recent samples removes short spikes. A phase counter that wraps once per bit is then pulled toward the filtered data transitions. The bit is captured when the counter reaches the middle of the bit. A one-cycle strobe goes out with it, and the strobe can load a receive shift register or FIFO directly.

The loop gain comes from a two-bit mode input. Fast tracking removes half of each measured timing error, rounded toward zero, so acquisition is quick. Slow tracking moves the counter by at most one sample per transition. This settles more slowly and needs better input timing, but it is far less disturbed by noise. Automatic tracking runs fast until lock is declared, runs slow while locked, and falls back to fast when lock is lost. Lock is judged from a run of small or large phase errors.

Top module: `fsk_bit_sync`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears its state. On the first cycle after release, `locked`, `rx_stb` and `rx_bit` are 0, and the phase counter starts at 0.
- R2: The data path uses the majority of the last 5 input samples. A pulse of 1 or 2 samples against the current level never changes a recovered bit.
- R3: `rx_stb` is never high for two cycles in a row. Once tracking has settled on periodic input, consecutive strobes are exactly 29 cycles apart.
- R4: With zero phase error, `rx_stb` goes high 18 clock cycles after the cycle in which a transition is applied to `rx_in`.
- R5: `rx_bit` changes only with a strobe. When `rx_stb` is high, `rx_bit` holds the value of the bit being received, sampled at its centre.
- R6: `trk_mode` encoding: 2'b00 is fast, 2'b01 is slow, and 2'b10 and 2'b11 are both automatic. The phase error of a transition is the counter value p when p < 14, or p - 29 otherwise, so the nominal edge is at 0. Fast mode subtracts half the error, truncated toward zero. Slow mode subtracts the sign of the error. A 10-sample timing step therefore keeps lock in fast mode.
- R7: `locked` rises after 8 consecutive transitions whose error magnitude is at most 2. In slow mode, after a 10-sample step that removes lock, lock returns on the 16th transition after the step and not on the 15th.
- R8: While locked, `locked` falls after 4 consecutive transitions whose error magnitude exceeds 6. In slow mode, a 10-sample timing step removes lock on its 4th transition. A 9-sample step never removes lock.
- R9: `fast_trk` shows the active gain. It is 1 in fast mode, 0 in slow mode, and in automatic mode it is the inverse of `locked`. So automatic mode drops to slow gain on lock and returns to fast gain when lock is lost.
- R10: A one-cycle synchronous reset during locked operation clears `locked` on the next cycle, and tracking restarts in the mode currently selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, 29 cycles per nominal bit |
| rst | input | 1 | Synchronous reset, active high |
| trk_mode | input | 2 | Tracking mode: 00 fast, 01 slow, 10/11 automatic |
| rx_in | input | 1 | Sliced serial data from the demodulator |
| rx_bit | output | 1 | Recovered bit, updated with each strobe |
| rx_stb | output | 1 | One-cycle strobe at the centre of each bit |
| locked | output | 1 | Phase tracking lock indication |
| fast_trk | output | 1 | High while the fast loop gain is applied |

## Verification
The hardest thing to reach from the ports is the exact lock-loss boundary. Losing lock after precisely four far-off transitions, and never after three, is only visible when the phase error is known to be zero before a controlled timing step. The stimulus gets there in slow mode. It sends periodic alternating data long enough for the error to settle to zero. It then stretches a single bit by 9 or 10 samples and probes `locked` a few cycles after each following transition, which lets the run of errors (10, 9, 8, 7, ...) be counted at the outputs. The same settled state gives the exact relock point and the fixed 18-cycle strobe latency.

// File: rtl/bs_pkg.sv
package bs_pkg;

   // Gain selection applied to the phase tracking loop
   typedef enum logic [1:0] {
      TRK_FAST     = 2'b00,
      TRK_SLOW     = 2'b01,
      TRK_AUTO     = 2'b10,
      TRK_AUTO_ALT = 2'b11
   } trk_mode_e;

endpackage

// File: rtl/bs_vote_filter.sv
module bs_vote_filter #(
   parameter int VOTE_LEN = 5
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic filt,
   output logic flip
);

   localparam int CW   = $clog2(VOTE_LEN + 1);
   localparam int NEED = VOTE_LEN / 2 + 1;

   generate
      if (VOTE_LEN < 1 || (VOTE_LEN % 2) == 0) begin : g_bad_len
         $error("bs_vote_filter: VOTE_LEN must be odd and positive");
      end
   endgenerate

   logic filt_q;

   generate
      if (VOTE_LEN == 1) begin : g_pass
         logic smp_q;
         always_ff @(posedge clk) begin
            if (rst) smp_q <= 1'b0;
            else     smp_q <= din;
         end
         assign filt = smp_q;
      end else begin : g_vote
         logic [VOTE_LEN-1:0] win_q;
         logic [CW-1:0]       ones;
         always_ff @(posedge clk) begin
            if (rst) win_q <= '0;
            else     win_q <= {win_q[VOTE_LEN-2:0], din};
         end
         always_comb begin
            ones = '0;
            for (int i = 0; i < VOTE_LEN; i++) ones = ones + CW'(win_q[i]);
         end
         assign filt = (ones >= CW'(NEED));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) filt_q <= 1'b0;
      else     filt_q <= filt;
   end

   assign flip = filt ^ filt_q;

   // R2: the vote only moves toward the sample that just entered the window
   a_r2_vote_follows_input: assert property (@(posedge clk) disable iff (rst)
      !$stable(filt) |-> (filt == $past(din)) || $past(rst));

endmodule

// File: rtl/bs_phase_loop.sv
module bs_phase_loop #(
   parameter int SPB        = 29,
   parameter int FAST_SHIFT = 1
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      flip,
   input  logic                      filt,
   input  logic                      fast,
   output logic signed [$clog2(SPB):0] err,
   output logic                      stb,
   output logic                      dat
);

   localparam int PW   = $clog2(SPB);
   localparam int HALF = SPB / 2;

   generate
      if (SPB < 9 || (SPB % 2) == 0) begin : g_bad_spb
         $error("bs_phase_loop: SPB must be odd and at least 9");
      end
      if (FAST_SHIFT < 1 || FAST_SHIFT >= PW) begin : g_bad_shift
         $error("bs_phase_loop: FAST_SHIFT out of range");
      end
   endgenerate

   logic [PW-1:0] cnt_q, cnt_d;

   // Error relative to the nominal edge at count 0, then gain and wrap
   always_comb begin
      int p;
      int e;
      int m;
      int c;
      int v;
      p = int'(cnt_q);
      e = (p < HALF) ? p : p - SPB;
      m = (e < 0) ? -e : e;
      if (fast) c = m >> FAST_SHIFT;
      else      c = (m != 0) ? 1 : 0;
      if (e < 0) c = -c;
      v = flip ? (p + 1 - c) : (p + 1);
      if (v < 0)          v = v + SPB;
      else if (v >= SPB)  v = v - SPB;
      cnt_d = PW'(v);
      err   = (PW+1)'(e);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         stb   <= 1'b0;
         dat   <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         stb   <= (cnt_q == PW'(HALF));
         if (cnt_q == PW'(HALF)) dat <= filt;
      end
   end

   // R3: the phase counter stays inside one bit period
   a_r3_phase_range: assert property (@(posedge clk) disable iff (rst)
      cnt_q < PW'(SPB));

   // R3: the strobe is a single-cycle pulse
   a_r3_single_strobe: assert property (@(posedge clk) disable iff (rst)
      stb |=> !stb);

   // R5: the recovered bit moves only together with a strobe
   a_r5_bit_moves_on_strobe: assert property (@(posedge clk) disable iff (rst)
      !$stable(dat) |-> stb || $past(rst));

endmodule

// File: rtl/bs_lock_mon.sv
module bs_lock_mon #(
   parameter int EW         = 6,
   parameter int LOCK_TOL   = 2,
   parameter int UNLOCK_TOL = 6,
   parameter int LOCK_RUN   = 8,
   parameter int UNLOCK_RUN = 4
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 flip,
   input  logic signed [EW-1:0] err,
   output logic                 locked
);

   localparam int GW = $clog2(LOCK_RUN + 1);
   localparam int BW = $clog2(UNLOCK_RUN + 1);

   generate
      if (LOCK_TOL < 0 || UNLOCK_TOL < LOCK_TOL) begin : g_bad_tol
         $error("bs_lock_mon: tolerances inconsistent");
      end
      if (LOCK_RUN < 1 || UNLOCK_RUN < 1) begin : g_bad_run
         $error("bs_lock_mon: run lengths must be positive");
      end
   endgenerate

   logic [GW-1:0] good_q;
   logic [BW-1:0] bad_q;
   logic          near, far;

   always_comb begin
      int a;
      a = int'(err);
      if (a < 0) a = -a;
      near = (a <= LOCK_TOL);
      far  = (a >  UNLOCK_TOL);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         locked <= 1'b0;
         good_q <= '0;
         bad_q  <= '0;
      end else if (flip) begin
         if (!locked) begin
            bad_q <= '0;
            if (near) begin
               if (good_q == GW'(LOCK_RUN - 1)) begin
                  locked <= 1'b1;
                  good_q <= '0;
               end else begin
                  good_q <= good_q + 1'b1;
               end
            end else begin
               good_q <= '0;
            end
         end else begin
            good_q <= '0;
            if (far) begin
               if (bad_q == BW'(UNLOCK_RUN - 1)) begin
                  locked <= 1'b0;
                  bad_q  <= '0;
               end else begin
                  bad_q <= bad_q + 1'b1;
               end
            end else begin
               bad_q <= '0;
            end
         end
      end
   end

   // R7: lock is only declared on a data transition
   a_r7_lock_on_transition: assert property (@(posedge clk) disable iff (rst)
      $rose(locked) |-> $past(flip));

   // R8: lock is only dropped on a data transition or by reset
   a_r8_unlock_on_transition: assert property (@(posedge clk) disable iff (rst)
      $fell(locked) |-> $past(flip) || $past(rst));

endmodule

// File: rtl/fsk_bit_sync.sv
module fsk_bit_sync
   import bs_pkg::*;
#(
   parameter int SPB        = 29,
   parameter int VOTE_LEN   = 5,
   parameter int FAST_SHIFT = 1,
   parameter int LOCK_TOL   = 2,
   parameter int UNLOCK_TOL = 6,
   parameter int LOCK_RUN   = 8,
   parameter int UNLOCK_RUN = 4
) (
   input  logic       clk,
   input  logic       rst,
   input  logic [1:0] trk_mode,
   input  logic       rx_in,
   output logic       rx_bit,
   output logic       rx_stb,
   output logic       locked,
   output logic       fast_trk
);

   localparam int EW = $clog2(SPB) + 1;

   generate
      if (VOTE_LEN >= SPB / 2) begin : g_bad_vote
         $error("fsk_bit_sync: vote window too long for the bit period");
      end
   endgenerate

   trk_mode_e        mode_e;
   logic             filt, flip;
   logic signed [EW-1:0] err;

   assign mode_e = trk_mode_e'(trk_mode);

   always_comb begin
      case (mode_e)
         TRK_FAST: fast_trk = 1'b1;
         TRK_SLOW: fast_trk = 1'b0;
         default:  fast_trk = !locked;
      endcase
   end

   bs_vote_filter #(
      .VOTE_LEN (VOTE_LEN)
   ) u_vote (
      .clk  (clk),
      .rst  (rst),
      .din  (rx_in),
      .filt (filt),
      .flip (flip)
   );

   bs_phase_loop #(
      .SPB        (SPB),
      .FAST_SHIFT (FAST_SHIFT)
   ) u_loop (
      .clk  (clk),
      .rst  (rst),
      .flip (flip),
      .filt (filt),
      .fast (fast_trk),
      .err  (err),
      .stb  (rx_stb),
      .dat  (rx_bit)
   );

   bs_lock_mon #(
      .EW         (EW),
      .LOCK_TOL   (LOCK_TOL),
      .UNLOCK_TOL (UNLOCK_TOL),
      .LOCK_RUN   (LOCK_RUN),
      .UNLOCK_RUN (UNLOCK_RUN)
   ) u_lock (
      .clk    (clk),
      .rst    (rst),
      .flip   (flip),
      .err    (err),
      .locked (locked)
   );

endmodule

// File: tb/fsk_bit_sync_tb.sv
module fsk_bit_sync_tb;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] trk_mode = 2'b10;
   logic       rx_in = 1'b0;
   logic       rx_bit, rx_stb, locked, fast_trk;

   int   n_chk = 0;
   int   n_bad = 0;
   int   step = 0;
   int   last_stb = -1;
   int   last_edge = 0;
   int   stb_lag = -1;
   bit   mon_en = 1'b0;
   bit   done = 1'b0;
   bit   ideal [0:63];
   logic prev_drv = 1'b0;
   logic cur = 1'b0;
   logic lk_hist [0:19];
   logic ft_hist [0:19];
   logic [15:0] lfsr = 16'hACE1;

   always #2 clk = ~clk;

   fsk_bit_sync u_dut (
      .clk      (clk),
      .rst      (rst),
      .trk_mode (trk_mode),
      .rx_in    (rx_in),
      .rx_bit   (rx_bit),
      .rx_stb   (rx_stb),
      .locked   (locked),
      .fast_trk (fast_trk)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // one sample period: observe outputs, then drive the next input sample
   task automatic tick(input logic v, input logic g);
      logic d;
      @(negedge clk);
      if (rx_stb) begin
         stb_lag = step - last_edge;
         if (mon_en) begin
            check(rx_bit === ideal[(step - 4) % 64], "R5", "bit at strobe",
                  int'(rx_bit), int'(ideal[(step - 4) % 64]));
            if (last_stb >= 0)
               check(step - last_stb == 29, "R3", "strobe spacing",
                     step - last_stb, 29);
            last_stb = step;
         end
      end
      d = v ^ g;
      rx_in = d;
      if (d !== prev_drv) last_edge = step;
      prev_drv = d;
      ideal[step % 64] = v;
      step++;
   endtask

   task automatic send_bit(input logic v, input int len, input int g_at, input int g_len);
      for (int i = 0; i < len; i++)
         tick(v, (i >= g_at && i < g_at + g_len) ? 1'b1 : 1'b0);
   endtask

   task automatic train(input int nbits);
      for (int b = 0; b < nbits; b++) begin
         cur = ~cur;
         send_bit(cur, 29, -1, 0);
      end
   endtask

   // stretch the current level by d samples, then probe n transitions
   task automatic jump_probe(input int d, input int n);
      send_bit(cur, d, -1, 0);
      for (int k = 1; k <= n; k++) begin
         cur = ~cur;
         for (int i = 0; i < 29; i++) begin
            tick(cur, 1'b0);
            if (i == 8) begin
               lk_hist[k] = locked;
               ft_hist[k] = fast_trk;
            end
         end
      end
   endtask

   task automatic do_reset(input logic [1:0] m);
      trk_mode = m;
      rst = 1'b1;
      tick(cur, 1'b0);
      tick(cur, 1'b0);
      rst = 1'b0;
   endtask

   task automatic mon_on();
      mon_en = 1'b1;
      last_stb = -1;
   endtask

   task automatic t_reset_state();
      rst = 1'b1;
      trk_mode = 2'b10;
      for (int i = 0; i < 4; i++) tick(1'b0, 1'b0);
      rst = 1'b0;
      tick(1'b0, 1'b0);
      check(locked === 1'b0, "R1", "locked after reset", int'(locked), 0);
      check(rx_stb === 1'b0, "R1", "strobe after reset", int'(rx_stb), 0);
      check(rx_bit === 1'b0, "R1", "bit after reset", int'(rx_bit), 0);
      check(fast_trk === 1'b1, "R9", "auto gain while unlocked", int'(fast_trk), 1);
   endtask

   task automatic t_fast_data();
      do_reset(2'b00);
      check(fast_trk === 1'b1, "R6", "fast mode gain", int'(fast_trk), 1);
      train(30);
      check(locked === 1'b1, "R7", "fast acquisition", int'(locked), 1);
      mon_on();
      for (int b = 0; b < 40; b++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         cur = lfsr[0];
         send_bit(cur, 29, -1, 0);
      end
      mon_en = 1'b0;
      check(locked === 1'b1, "R7", "lock kept on random data", int'(locked), 1);
   endtask

   task automatic t_glitch();
      mon_on();
      for (int b = 0; b < 40; b++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         cur = lfsr[0];
         if (b % 2 == 0) send_bit(cur, 29, 13, 2);
         else            send_bit(cur, 29, 5, 1);
      end
      mon_en = 1'b0;
      check(locked === 1'b1, "R2", "lock kept under spikes", int'(locked), 1);
   endtask

   task automatic t_slow_bounds();
      do_reset(2'b01);
      check(fast_trk === 1'b0, "R9", "slow mode gain", int'(fast_trk), 0);
      train(45);
      check(locked === 1'b1, "R7", "slow acquisition", int'(locked), 1);
      mon_on();
      train(10);
      mon_en = 1'b0;
      check(stb_lag == 18, "R4", "edge to strobe latency", stb_lag, 18);
      jump_probe(9, 4);
      for (int k = 1; k <= 4; k++)
         check(lk_hist[k] === 1'b1, "R8", "9-sample step keeps lock", int'(lk_hist[k]), 1);
      train(15);
      jump_probe(10, 16);
      for (int k = 1; k <= 3; k++)
         check(lk_hist[k] === 1'b1, "R8", "lock before 4th far edge", int'(lk_hist[k]), 1);
      check(lk_hist[4] === 1'b0, "R8", "lock lost on 4th far edge", int'(lk_hist[4]), 0);
      check(lk_hist[15] === 1'b0, "R7", "no relock on 15th edge", int'(lk_hist[15]), 0);
      check(lk_hist[16] === 1'b1, "R7", "relock on 16th edge", int'(lk_hist[16]), 1);
   endtask

   task automatic t_fast_hold();
      do_reset(2'b00);
      train(30);
      jump_probe(10, 6);
      for (int k = 1; k <= 6; k++)
         check(lk_hist[k] === 1'b1, "R6", "fast gain holds lock over step", int'(lk_hist[k]), 1);
   endtask

   task automatic t_auto();
      do_reset(2'b10);
      check(fast_trk === 1'b1, "R9", "auto starts fast", int'(fast_trk), 1);
      train(40);
      check(locked === 1'b1, "R9", "auto locks", int'(locked), 1);
      check(fast_trk === 1'b0, "R9", "auto slow when locked", int'(fast_trk), 0);
      jump_probe(12, 4);
      check(lk_hist[3] === 1'b1, "R8", "auto lock before 4th far edge", int'(lk_hist[3]), 1);
      check(ft_hist[3] === 1'b0, "R9", "auto gain before loss", int'(ft_hist[3]), 0);
      check(lk_hist[4] === 1'b0, "R8", "auto lock lost", int'(lk_hist[4]), 0);
      check(ft_hist[4] === 1'b1, "R9", "auto back to fast", int'(ft_hist[4]), 1);
      train(30);
      check(locked === 1'b1, "R9", "auto relocks", int'(locked), 1);
      check(fast_trk === 1'b0, "R9", "auto slow after relock", int'(fast_trk), 0);
   endtask

   task automatic t_midrun_reset();
      do_reset(2'b11);
      check(fast_trk === 1'b1, "R6", "mode 11 is automatic", int'(fast_trk), 1);
      train(40);
      check(locked === 1'b1, "R10", "locked before reset", int'(locked), 1);
      rst = 1'b1;
      tick(cur, 1'b0);
      rst = 1'b0;
      tick(cur, 1'b0);
      check(locked === 1'b0, "R10", "reset clears lock", int'(locked), 0);
      check(fast_trk === 1'b1, "R10", "restart in automatic fast", int'(fast_trk), 1);
      train(40);
      check(locked === 1'b1, "R10", "relock after reset", int'(locked), 1);
   endtask

   initial begin
      t_reset_state();
      t_fast_data();
      t_glitch();
      t_slow_bounds();
      t_fast_hold();
      t_auto();
      t_midrun_reset();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog run did not complete actual=%0d expected=%0d", step, 0);
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule